// File: doc/BRIEF.md
# Port-Size-Aware DRAM Address Multiplexer

This block turns a logical byte address into the address driven onto a shared set of DRAM address pins. An asynchronous DRAM access has a row phase and a column phase, and the same pins carry a different slice of the logical address in each. A small access sequencer sets the phase. The bank's programmed port width (8, 16 or 32 bits) decides which low address bits are meaningful in the column phase, and what one remapped pin (pin 17) carries.

The block also records the page (a fixed 512-byte region) opened by the most recent row phase. It raises a combinational page-hit flag when the presented address falls in that page under the same width setting, so that the sequencer can go straight to a column phase. Strobe timing, refresh and data lane steering belong to other blocks.

Top module: `dram_addr_mux`

## Requirements
- R1: While reset (`rst_ni` low) is applied and in the first cycle after it is released, `pin_addr_o` is all zeros and `page_hit_o` is low.
- R2: A row phase (`phase_i` = 2'b01) loads pin N with logical bit N+9 for every pin. Pins whose bit N+9 is beyond the address width drive 0. The mapping is the same for every width setting.
- R3: A column phase (`phase_i` = 2'b10) loads every pin N other than pin 17 with logical bit N, subject to R4. Pins at or above the address width drive 0.
- R4: In a column phase, a 16-bit setting (`port_size_i` = 2'b10) forces pin 0 to 0. A 32-bit setting (2'b00, or 2'b11 which is treated the same) forces pins 0 and 1 to 0. An 8-bit setting (2'b01) forces neither.
- R5: In a column phase, pin 17 carries logical bit 0 under the 8-bit setting and logical bit 16 under every other setting.
- R6: `pin_addr_o` is registered. It takes its new value at the clock edge that samples a row or column phase. In idle (2'b00) or the unused code 2'b11, it holds its value whatever the address.
- R7: `page_hit_o` is combinational. It is high only if a page is open, `addr_i[ADDR_W-1:9]` equals the open page number, and `port_size_i` equals the setting under which that page was opened.
- R8: Any change of the `port_size_i` field value closes the open page. `page_hit_o` stays low from that cycle until the next row phase, even if the field returns to its earlier value.
- R9: A row phase opens the page of the address it samples, together with the current width setting. From the next cycle, an address anywhere in that 512-byte page gives a hit, and an address in any other page does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| phase_i | input | 2 | Access phase: 00 idle, 01 row, 10 column, 11 idle |
| port_size_i | input | 2 | Bank width: 00 32-bit, 01 8-bit, 10 16-bit, 11 32-bit |
| addr_i | input | ADDR_W | Logical byte address |
| pin_addr_o | output | PIN_W | Registered multiplexed address pins |
| page_hit_o | output | 1 | Address lies in the open page under the same width setting |

## Verification
The case that is hardest to reach is the closing of the open page by a width change that is later undone. The field returns to the value the page was opened under, so the address and the setting both match again, and only the closed state keeps the hit low. The stimulus opens a page, flips `port_size_i` away and back while holding an in-page address, checks that no hit returns, and then issues a fresh row phase to reopen it. Walking-one addresses under every width code cover each pin's row and column source one bit at a time.

// File: rtl/dram_amux_pkg.sv
package dram_amux_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ROW  = 2'b01,
    PH_COL  = 2'b10,
    PH_RSVD = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    PS_W32  = 2'b00,
    PS_W8   = 2'b01,
    PS_W16  = 2'b10,
    PS_W32X = 2'b11
  } psize_e;

  localparam int PAGE_BITS = 9;   // 512-byte page
  localparam int REMAP_PIN = 17;  // pin whose column source depends on width

  // Low column pins that carry no information for a given width.
  function automatic logic [1:0] low_drop_mask(input logic [1:0] ps);
    case (ps)
      PS_W8:   low_drop_mask = 2'b00;
      PS_W16:  low_drop_mask = 2'b01;
      default: low_drop_mask = 2'b11;
    endcase
  endfunction

  function automatic logic is_byte_port(input logic [1:0] ps);
    is_byte_port = (ps == PS_W8);
  endfunction

endpackage

// File: rtl/damux_map.sv
module damux_map
  import dram_amux_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PIN_W  = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [PIN_W-1:0]  row_word_o,
  output logic [PIN_W-1:0]  col_word_o
);

  logic [PIN_W-1:0] col_raw;
  logic             byte_mode;
  logic [1:0]       drop;

  assign byte_mode = is_byte_port(size_i);
  assign drop      = low_drop_mask(size_i);

  for (genvar n = 0; n < PIN_W; n++) begin : g_pin
    if (n + PAGE_BITS < ADDR_W) begin : g_row_bit
      assign row_word_o[n] = addr_i[n + PAGE_BITS];
    end else begin : g_row_zero
      assign row_word_o[n] = 1'b0;
    end

    if (n == REMAP_PIN) begin : g_col_remap
      assign col_raw[n] = byte_mode ? addr_i[0] : addr_i[16];
    end else if (n < ADDR_W) begin : g_col_bit
      assign col_raw[n] = addr_i[n];
    end else begin : g_col_zero
      assign col_raw[n] = 1'b0;
    end
  end

  assign col_word_o = {col_raw[PIN_W-1:2], col_raw[1:0] & ~drop};

endmodule

// File: rtl/damux_page_trk.sv
module damux_page_trk
  import dram_amux_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              hit_o,
  output logic              valid_o
);

  localparam int TAG_W = ADDR_W - PAGE_BITS;

  logic [TAG_W-1:0] open_tag_q;
  logic [1:0]       open_size_q;
  logic             valid_q;
  logic [TAG_W-1:0] cur_tag;
  logic             size_same;

  assign cur_tag   = addr_i[ADDR_W-1:PAGE_BITS];
  assign size_same = (size_i == open_size_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_q     <= 1'b0;
      open_tag_q  <= '0;
      open_size_q <= '0;
    end else if (open_i) begin
      valid_q     <= 1'b1;
      open_tag_q  <= cur_tag;
      open_size_q <= size_i;
    end else if (!size_same) begin
      valid_q     <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign hit_o   = valid_q && size_same && (cur_tag == open_tag_q);

endmodule

// File: rtl/damux_pin_reg.sv
module damux_pin_reg
  import dram_amux_pkg::*;
#(
  parameter int PIN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_row_i,
  input  logic             load_col_i,
  input  logic [PIN_W-1:0] row_word_i,
  input  logic [PIN_W-1:0] col_word_i,
  output logic [PIN_W-1:0] pins_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pins_o <= '0;
    end else if (load_row_i) begin
      pins_o <= row_word_i;
    end else if (load_col_i) begin
      pins_o <= col_word_i;
    end
  end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_amux_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PIN_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        phase_i,
  input  logic [1:0]        port_size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PIN_W-1:0]  pin_addr_o,
  output logic              page_hit_o
);

  logic             row_open;
  logic             col_drive;
  logic             page_valid;
  logic [PIN_W-1:0] row_word;
  logic [PIN_W-1:0] col_word;

  assign row_open  = (phase_i == PH_ROW);
  assign col_drive = (phase_i == PH_COL);

  damux_map #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_map (
    .addr_i     (addr_i),
    .size_i     (port_size_i),
    .row_word_o (row_word),
    .col_word_o (col_word)
  );

  damux_pin_reg #(.PIN_W(PIN_W)) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_row_i (row_open),
    .load_col_i (col_drive),
    .row_word_i (row_word),
    .col_word_i (col_word),
    .pins_o     (pin_addr_o)
  );

  damux_page_trk #(.ADDR_W(ADDR_W)) u_page (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .open_i  (row_open),
    .addr_i  (addr_i),
    .size_i  (port_size_i),
    .hit_o   (page_hit_o),
    .valid_o (page_valid)
  );

endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk #(
  parameter int ADDR_W = 24,
  parameter int PIN_W  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        phase_i,
  input logic [1:0]        port_size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PIN_W-1:0]  pin_addr_o,
  input logic              page_hit_o,
  input logic              page_valid
);

  AST_ROW_PIN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == 2'b01 |=> pin_addr_o[0] == $past(addr_i[9])); // R2

  AST_COL_PIN5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == 2'b10 |=> pin_addr_o[5] == $past(addr_i[5])); // R3

  AST_COL_DROP_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b10 && (port_size_i == 2'b00 || port_size_i == 2'b11))
      |=> pin_addr_o[1:0] == 2'b00); // R4

  AST_COL_DROP_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b10 && port_size_i == 2'b10) |=> pin_addr_o[0] == 1'b0); // R4

  AST_PIN17_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b10 && port_size_i == 2'b01)
      |=> pin_addr_o[17] == $past(addr_i[0])); // R5

  AST_PIN17_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b10 && port_size_i != 2'b01)
      |=> pin_addr_o[17] == $past(addr_i[16])); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b00 || phase_i == 2'b11) |=> $stable(pin_addr_o)); // R6

  AST_HIT_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_hit_o |-> page_valid); // R7

  AST_SIZE_CHANGE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_size_i != $past(port_size_i) |-> !page_hit_o); // R8

  AST_ROW_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == 2'b01 |=> page_valid); // R9

endmodule

bind dram_addr_mux dram_addr_mux_chk #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_i     (phase_i),
  .port_size_i (port_size_i),
  .addr_i      (addr_i),
  .pin_addr_o  (pin_addr_o),
  .page_hit_o  (page_hit_o),
  .page_valid  (page_valid)
);

// File: tb/dram_addr_mux_tb.sv
`timescale 1ns/100ps
module dram_addr_mux_tb;

  localparam int AW = 24;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    phase = 2'b00;
  logic [1:0]    psize = 2'b01;
  logic [AW-1:0] addr = '0;
  logic [PW-1:0] pins;
  logic          hit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_addr_mux #(.ADDR_W(AW), .PIN_W(PW)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .phase_i     (phase),
    .port_size_i (psize),
    .addr_i      (addr),
    .pin_addr_o  (pins),
    .page_hit_o  (hit)
  );

  function automatic logic [PW-1:0] exp_row(input logic [AW-1:0] a);
    logic [PW-1:0] r = '0;
    for (int n = 0; n < PW; n++)
      if (n + 9 < AW) r[n] = a[n + 9];
    return r;
  endfunction

  function automatic logic [PW-1:0] exp_col(input logic [AW-1:0] a, input logic [1:0] s);
    logic [PW-1:0] r = '0;
    for (int n = 0; n < PW; n++) begin
      if (n == 17)      r[n] = (s == 2'b01) ? a[0] : a[16];
      else if (n < AW)  r[n] = a[n];
    end
    if (s != 2'b01) r[0] = 1'b0;
    if (s == 2'b00 || s == 2'b11) r[1] = 1'b0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] ph, input logic [AW-1:0] a, input logic [1:0] s);
    phase = ph; addr = a; psize = s;
    #1;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [PW-1:0] held;
    logic [AW-1:0] base;
    repeat (3) tick();
    chk(pins == '0, "R1 pins in reset", 32'(pins), 0);
    chk(hit == 1'b0, "R1 hit in reset", 32'(hit), 0);
    rst_n = 1'b1;
    drive(2'b00, 24'hABCDEF, 2'b01);
    chk(hit == 1'b0, "R1 hit after release", 32'(hit), 0);
    tick();
    chk(pins == '0, "R1 pins after release", 32'(pins), 0);

    // Sweep: all width codes, pseudo-random and walking-one addresses.
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < AW + 40; k++) begin
        logic [AW-1:0] a;
        a = (k < AW) ? (AW'(1) << k) : AW'(k * 32'h9E3779B1 + s * 32'h0123457);
        drive(2'b01, a, 2'(s));
        tick();
        chk(pins == exp_row(a), "R2 row map", 32'(pins), 32'(exp_row(a)));
        drive(2'b10, a, 2'(s));
        chk(hit == 1'b1, "R9 same page after row", 32'(hit), 1);
        tick();
        chk(pins == exp_col(a, 2'(s)), "R3 R4 R5 column map", 32'(pins),
            32'(exp_col(a, 2'(s))));
        held = pins;
        drive((k % 2 == 0) ? 2'b00 : 2'b11, ~a, 2'(s));
        tick();
        chk(pins == held, "R6 idle holds", 32'(pins), 32'(held));
      end
    end

    // Directed: pin 17 and dropped bits per width.
    drive(2'b10, 24'h010001, 2'b01); tick();
    chk(pins[17] == 1'b1, "R5 byte pin17 from bit0", 32'(pins[17]), 1);
    drive(2'b10, 24'h000001, 2'b10); tick();
    chk(pins[17] == 1'b0 && pins[0] == 1'b0, "R4 R5 half width", 32'(pins), 0);
    drive(2'b10, 24'h010003, 2'b11); tick();
    chk(pins[1:0] == 2'b00 && pins[17] == 1'b1, "R4 R5 code 11 as 32-bit",
        32'(pins), 32'h20000);

    // Page tracking.
    base = 24'h5A3600;
    drive(2'b01, base, 2'b01); tick();
    drive(2'b00, base | 24'h1FF, 2'b01);
    chk(hit == 1'b1, "R9 in-page top byte", 32'(hit), 1);
    drive(2'b00, base ^ 24'h200, 2'b01);
    chk(hit == 1'b0, "R9 next page", 32'(hit), 0);
    drive(2'b00, base ^ 24'h800000, 2'b01);
    chk(hit == 1'b0, "R7 high tag bit differs", 32'(hit), 0);
    drive(2'b00, base, 2'b10);
    chk(hit == 1'b0, "R8 width changed", 32'(hit), 0);
    tick();
    drive(2'b00, base, 2'b01);
    chk(hit == 1'b0, "R8 width restored", 32'(hit), 0);
    tick();
    chk(hit == 1'b0, "R8 still closed", 32'(hit), 0);
    drive(2'b01, base, 2'b01); tick();
    drive(2'b00, base, 2'b01);
    chk(hit == 1'b1, "R9 reopened", 32'(hit), 1);
    tick();
    rst_n = 1'b0; tick();
    chk(hit == 1'b0 && pins == '0, "R1 mid-run reset", 32'(pins), 0);
    rst_n = 1'b1;
    drive(2'b00, base, 2'b01);
    chk(hit == 1'b0, "R8 reset closes page", 32'(hit), 0);
    tick();

    finish_run();
  end

endmodule